// File: doc/BRIEF.md
# PCM Bit-Clock and Frame-Sync Generator

This block is the timing master of a short-frame PCM audio port. It picks one of two source clock-enable streams (a peripheral-clock tick or an external audio-clock tick) and divides it down to a serial bit clock. It then groups bit clocks into frames and raises a one-bit-clock-wide frame-sync pulse at the start of each frame. Data changes on the falling edge of the bit clock and is sampled on the rising edge. The sync pulse is active high.

For the serializer next to it, the block produces two lanes of bit timing. The transmit lane gives a one-cycle shift strobe at the start of each data bit slot. The receive lane gives a one-cycle sample strobe at the rising bit-clock edge of each data slot. Each lane also carries a bit index that counts down from 15 (the MSB) to 0 over the 16 data bits. Each lane can place the MSB either in the same slot as the sync pulse or one slot later.

The two divider fields and the two MSB-placement bits are shadowed. A change takes effect only at a frame boundary, so no runt bit clock or runt sync pulse can appear.

Top module: `pcm_clk_gen`

## Requirements
- R1: While reset is asserted, and after it is released with the serial clock disabled, bitClk, frameSync, txShift, txValid, rxSample and rxValid are all low.
- R2: While serClkEn is low, bitClk and frameSync stay low and no strobes are issued. One clock after serClkEn is first seen high, slot 0 begins: frameSync is high, bitClk is low, and the slot-start strobe fires.
- R3: One bitClk period lasts 2×(bitDivCfg+1) ticks of the selected source, low half first. A rising edge of bitClk only follows a selected source tick.
- R4: srcSel = 1 selects periphTick as the divider input and srcSel = 0 selects audioTick.
- R5: A frame lasts frameDivCfg+1 bit-clock periods. frameSync is high for exactly slot 0, which is one bit-clock period starting in the low half.
- R6: txShift pulses for one clock at the start of each transmit data slot, while bitClk is low. It comes with txBitIdx counting 15, 14, …, 0, exactly 16 pulses per frame when the frame is long enough.
- R7: txLate = 0 puts the transmit MSB (index 15) in slot 0, together with frameSync. txLate = 1 puts it in slot 1. rxLate places the receive MSB the same way.
- R8: rxSample pulses for one clock in the cycle bitClk rises inside each receive data slot, with rxBitIdx counting 15 down to 0, 16 per frame.
- R9: New bitDivCfg and frameDivCfg values written in mid-frame leave the current frame's length unchanged and apply from the next frame.
- R10: Slots after the 16 data bits carry no data: txValid and rxValid are low in the last slot of a frame longer than 17 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphTick | input | 1 | Peripheral source clock-enable tick |
| audioTick | input | 1 | External audio source clock-enable tick |
| srcSel | input | 1 | 1 selects periphTick, 0 selects audioTick |
| serClkEn | input | 1 | Serial clock enable; low holds the port idle |
| bitDivCfg | input | 9 | Half-period divider; bit period = 2×(value+1) ticks |
| frameDivCfg | input | 9 | Frame length minus one, in bit clocks |
| txLate | input | 1 | Transmit MSB one slot after sync when set |
| rxLate | input | 1 | Receive MSB one slot after sync when set |
| bitClk | output | 1 | Serial bit clock |
| frameSync | output | 1 | Frame-sync pulse, high during slot 0 |
| txShift | output | 1 | One-cycle strobe at each transmit data slot start |
| txValid | output | 1 | Current slot holds a transmit data bit |
| txBitIdx | output | 4 | Transmit bit index, 15 down to 0 |
| rxSample | output | 1 | One-cycle strobe at the rising edge of each receive data slot |
| rxValid | output | 1 | Current slot holds a receive data bit |
| rxBitIdx | output | 4 | Receive bit index, 15 down to 0 |

## Verification
The bench builds the block with its default parameters: 9-bit divider fields and 16-bit samples. It programs small divider values, so frames of 20 to 25 slots complete in tens to a few hundred cycles. These short frames reach both the data slots and the empty tail slots after bit 0, the early and late MSB placements, and a divider change in mid-frame. A slow audio tick is also used, so that an error in the source selection changes the measured period by a factor of three.

// File: rtl/pcm_clk_pkg.sv
package pcm_clk_pkg;

  // Edge events decided by the clock control for the current cycle.
  typedef struct packed {
    logic start;  // port leaves idle, slot 0 begins next cycle
    logic stop;   // port returns to idle
    logic rise;   // bit clock goes high at this edge
    logic fall;   // bit clock goes low at this edge, next slot begins
  } edgeStb_t;

endpackage

// File: rtl/pcm_slot_lane.sv
module pcm_slot_lane #(
  parameter int DIV_W    = 9,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 4
) (
  input  logic             active,
  input  logic [DIV_W-1:0] bitPos,
  input  logic             late,
  input  logic             fireIn,
  output logic             inData,
  output logic [IDX_W-1:0] idx,
  output logic             fire
);

  localparam int EXT_W = DIV_W + 1;

  logic [EXT_W-1:0] posExt;
  logic [EXT_W-1:0] firstSlot;
  logic [EXT_W-1:0] offset;
  logic [EXT_W-1:0] reversed;

  always_comb begin
    posExt    = {1'b0, bitPos};
    firstSlot = {{DIV_W{1'b0}}, late};
    offset    = posExt - firstSlot;
    inData    = active && (posExt >= firstSlot) && (offset < EXT_W'(SAMPLE_W));
    reversed  = EXT_W'(SAMPLE_W - 1) - offset;
    idx       = inData ? reversed[IDX_W-1:0] : '0;
    fire      = fireIn && inData;
  end

endmodule

// File: rtl/pcm_clk_ctrl.sv
module pcm_clk_ctrl
  import pcm_clk_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphTick,
  input  logic             audioTick,
  input  logic             srcSel,
  input  logic             serClkEn,
  input  logic [DIV_W-1:0] bitDivCfg,
  input  logic             lastSlot,
  output edgeStb_t         stb,
  output logic             bitClk
);

  logic             run;
  logic             phase;
  logic [DIV_W-1:0] halfCnt;
  logic [DIV_W-1:0] bitDivQ;
  logic             srcTick;
  logic             halfDone;

  always_comb begin
    srcTick   = srcSel ? periphTick : audioTick;
    halfDone  = run && serClkEn && srcTick && (halfCnt == bitDivQ);
    stb.start = serClkEn && !run;
    stb.stop  = run && !serClkEn;
    stb.rise  = halfDone && !phase;
    stb.fall  = halfDone && phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run     <= 1'b0;
      phase   <= 1'b0;
      halfCnt <= '0;
      bitDivQ <= '0;
    end else if (!serClkEn) begin
      run     <= 1'b0;
      phase   <= 1'b0;
      halfCnt <= '0;
    end else if (!run) begin
      run     <= 1'b1;
      phase   <= 1'b0;
      halfCnt <= '0;
      bitDivQ <= bitDivCfg;
    end else if (srcTick) begin
      if (halfCnt == bitDivQ) begin
        halfCnt <= '0;
        phase   <= ~phase;
        if (phase && lastSlot) bitDivQ <= bitDivCfg;
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end

  assign bitClk = phase;

endmodule

// File: rtl/pcm_frame_dp.sv
module pcm_frame_dp
  import pcm_clk_pkg::*;
#(
  parameter int DIV_W    = 9,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  edgeStb_t         stb,
  input  logic [DIV_W-1:0] frameDivCfg,
  input  logic             txLate,
  input  logic             rxLate,
  output logic             lastSlot,
  output logic             frameSync,
  output logic             txShift,
  output logic             txValid,
  output logic [IDX_W-1:0] txBitIdx,
  output logic             rxSample,
  output logic             rxValid,
  output logic [IDX_W-1:0] rxBitIdx
);

  localparam int LANES = 2;  // lane 0 transmit, lane 1 receive

  logic             active;
  logic [DIV_W-1:0] bitPos;
  logic [DIV_W-1:0] frameDivQ;
  logic [LANES-1:0] lateQ;
  logic             slotPulse;
  logic             risePulse;

  logic [LANES-1:0] laneFireIn;
  logic [LANES-1:0] laneValid;
  logic [LANES-1:0] laneFire;
  logic [IDX_W-1:0] laneIdx [LANES];

  assign lastSlot  = active && (bitPos == frameDivQ);
  assign frameSync = active && (bitPos == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      bitPos    <= '0;
      frameDivQ <= '0;
      lateQ     <= '0;
      slotPulse <= 1'b0;
      risePulse <= 1'b0;
    end else if (stb.stop) begin
      active    <= 1'b0;
      bitPos    <= '0;
      slotPulse <= 1'b0;
      risePulse <= 1'b0;
    end else if (stb.start) begin
      active    <= 1'b1;
      bitPos    <= '0;
      frameDivQ <= frameDivCfg;
      lateQ     <= {rxLate, txLate};
      slotPulse <= 1'b1;
      risePulse <= 1'b0;
    end else begin
      risePulse <= stb.rise;
      slotPulse <= stb.fall;
      if (stb.fall) begin
        if (lastSlot) begin
          bitPos    <= '0;
          frameDivQ <= frameDivCfg;
          lateQ     <= {rxLate, txLate};
        end else begin
          bitPos <= bitPos + DIV_W'(1);
        end
      end
    end
  end

  assign laneFireIn = {risePulse, slotPulse};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    pcm_slot_lane #(
      .DIV_W   (DIV_W),
      .SAMPLE_W(SAMPLE_W),
      .IDX_W   (IDX_W)
    ) u_lane (
      .active(active),
      .bitPos(bitPos),
      .late  (lateQ[g]),
      .fireIn(laneFireIn[g]),
      .inData(laneValid[g]),
      .idx   (laneIdx[g]),
      .fire  (laneFire[g])
    );
  end

  assign txShift  = laneFire[0];
  assign txValid  = laneValid[0];
  assign txBitIdx = laneIdx[0];
  assign rxSample = laneFire[1];
  assign rxValid  = laneValid[1];
  assign rxBitIdx = laneIdx[1];

endmodule

// File: rtl/pcm_clk_gen.sv
module pcm_clk_gen
  import pcm_clk_pkg::*;
#(
  parameter int DIV_W    = 9,
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = $clog2(SAMPLE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periphTick,
  input  logic             audioTick,
  input  logic             srcSel,
  input  logic             serClkEn,
  input  logic [DIV_W-1:0] bitDivCfg,
  input  logic [DIV_W-1:0] frameDivCfg,
  input  logic             txLate,
  input  logic             rxLate,
  output logic             bitClk,
  output logic             frameSync,
  output logic             txShift,
  output logic             txValid,
  output logic [IDX_W-1:0] txBitIdx,
  output logic             rxSample,
  output logic             rxValid,
  output logic [IDX_W-1:0] rxBitIdx
);

  edgeStb_t stb;
  logic     lastSlot;

  pcm_clk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periphTick(periphTick),
    .audioTick (audioTick),
    .srcSel    (srcSel),
    .serClkEn  (serClkEn),
    .bitDivCfg (bitDivCfg),
    .lastSlot  (lastSlot),
    .stb       (stb),
    .bitClk    (bitClk)
  );

  pcm_frame_dp #(
    .DIV_W   (DIV_W),
    .SAMPLE_W(SAMPLE_W),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .frameDivCfg(frameDivCfg),
    .txLate     (txLate),
    .rxLate     (rxLate),
    .lastSlot   (lastSlot),
    .frameSync  (frameSync),
    .txShift    (txShift),
    .txValid    (txValid),
    .txBitIdx   (txBitIdx),
    .rxSample   (rxSample),
    .rxValid    (rxValid),
    .rxBitIdx   (rxBitIdx)
  );

endmodule

// File: rtl/pcm_clk_gen_sva.sv
module pcm_clk_gen_sva #(
  parameter int SAMPLE_W = 16,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             periphTick,
  input logic             audioTick,
  input logic             srcSel,
  input logic             serClkEn,
  input logic             bitClk,
  input logic             frameSync,
  input logic             txShift,
  input logic             txValid,
  input logic [IDX_W-1:0] txBitIdx,
  input logic             rxSample,
  input logic             rxValid
);

  logic [IDX_W-1:0] lastTxIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastTxIdx <= '0;
    else if (txShift) lastTxIdx <= txBitIdx;
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !serClkEn |=> (!bitClk && !frameSync)); // R2

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitClk) |-> $past(srcSel ? periphTick : audioTick)); // R4

  AST_SYNC_IN_LOW_HALF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |-> !bitClk); // R5

  AST_TX_SHIFT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    txShift |-> (txValid && !bitClk)); // R6

  AST_TX_IDX_DESC: assert property (@(posedge clk) disable iff (!rstN)
    (txShift && txBitIdx != IDX_W'(SAMPLE_W - 1)) |-> (txBitIdx == lastTxIdx - IDX_W'(1))); // R6

  AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rxSample |-> (rxValid && $rose(bitClk))); // R8

endmodule

bind pcm_clk_gen pcm_clk_gen_sva #(
  .SAMPLE_W(SAMPLE_W),
  .IDX_W   (IDX_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .periphTick(periphTick),
  .audioTick (audioTick),
  .srcSel    (srcSel),
  .serClkEn  (serClkEn),
  .bitClk    (bitClk),
  .frameSync (frameSync),
  .txShift   (txShift),
  .txValid   (txValid),
  .txBitIdx  (txBitIdx),
  .rxSample  (rxSample),
  .rxValid   (rxValid)
);

// File: tb/pcm_clk_gen_tb.sv
`timescale 1ns/1ps
module pcm_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       periphTick;
  logic       audioTick;
  logic       srcSel;
  logic       serClkEn;
  logic [8:0] bitDivCfg;
  logic [8:0] frameDivCfg;
  logic       txLate;
  logic       rxLate;
  logic       bitClk;
  logic       frameSync;
  logic       txShift;
  logic       txValid;
  logic [3:0] txBitIdx;
  logic       rxSample;
  logic       rxValid;
  logic [3:0] rxBitIdx;

  always #10 clk = ~clk;  // 50 MHz

  pcm_clk_gen u_dut (
    .clk(clk), .rstN(rstN), .periphTick(periphTick), .audioTick(audioTick),
    .srcSel(srcSel), .serClkEn(serClkEn), .bitDivCfg(bitDivCfg),
    .frameDivCfg(frameDivCfg), .txLate(txLate), .rxLate(rxLate),
    .bitClk(bitClk), .frameSync(frameSync), .txShift(txShift),
    .txValid(txValid), .txBitIdx(txBitIdx), .rxSample(rxSample),
    .rxValid(rxValid), .rxBitIdx(rxBitIdx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard queues: entry = index*2 + expected frameSync at the strobe.
  int txQ[$];
  int rxQ[$];

  task automatic pushFrame(input bit tLate, input bit rLate);
    for (int k = 0; k < 16; k++) begin
      txQ.push_back((15 - k) * 2 + ((k == 0 && !tLate) ? 1 : 0));
      rxQ.push_back((15 - k) * 2 + ((k == 0 && !rLate) ? 1 : 0));
    end
  endtask

  // Monitor: measurements and scoreboard pops, sampled at negedge.
  int  cyc = 0;
  bit  prevBit = 0, prevSync = 0, prevTxV = 0, prevRxV = 0;
  int  lastBitRise = 0, bitPeriod = 0, bitRiseCnt = 0;
  int  lastSyncRise = 0, framePeriod = 0, syncRiseCnt = 0, syncWidth = 0;
  int  txCnt = 0, rxCnt = 0, txPerFrame = 0, rxPerFrame = 0;
  bit  validBeforeSync = 0;

  always @(negedge clk) begin
    cyc++;
    if (bitClk && !prevBit) begin
      bitPeriod = cyc - lastBitRise;
      lastBitRise = cyc;
      bitRiseCnt++;
    end
    if (frameSync && !prevSync) begin
      framePeriod = cyc - lastSyncRise;
      lastSyncRise = cyc;
      syncRiseCnt++;
      txPerFrame = txCnt;
      rxPerFrame = rxCnt;
      txCnt = 0;
      rxCnt = 0;
      validBeforeSync = prevTxV | prevRxV;
    end
    if (!frameSync && prevSync) syncWidth = cyc - lastSyncRise;
    if (txShift) begin
      txCnt++;
      if (txQ.size() > 0) begin
        int e, got;
        e = txQ.pop_front();
        got = int'(txBitIdx) * 2 + int'(frameSync);
        chk(got == e, "R6/R7 tx index*2+sync", got, e);
      end
    end
    if (rxSample) begin
      rxCnt++;
      if (rxQ.size() > 0) begin
        int e, got;
        e = rxQ.pop_front();
        got = int'(rxBitIdx) * 2 + int'(frameSync);
        chk(got == e, "R8/R7 rx index*2+sync", got, e);
      end
    end
    prevBit = bitClk;
    prevSync = frameSync;
    prevTxV = txValid;
    prevRxV = rxValid;
  end

  task automatic waitSync(input int n);
    int target;
    target = syncRiseCnt + n;
    while (syncRiseCnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stopPort();
    serClkEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Audio source tick: one every third cycle.
  initial begin
    int aCnt;
    aCnt = 0;
    audioTick = 1'b0;
    forever begin
      @(negedge clk);
      aCnt = (aCnt + 1) % 3;
      audioTick = (aCnt == 0);
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rises;
    rstN = 1'b0; serClkEn = 1'b0; srcSel = 1'b1; periphTick = 1'b1;
    bitDivCfg = 9'd0; frameDivCfg = 9'd19; txLate = 1'b0; rxLate = 1'b0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk({bitClk, frameSync, txShift, txValid, rxSample, rxValid} == 6'b0,
        "R1 outputs in reset", int'(bitClk), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({bitClk, frameSync, txShift, txValid, rxSample, rxValid} == 6'b0,
        "R1 outputs after reset", int'(frameSync), 0);

    // R2: disabled port stays idle despite ticks
    rises = bitRiseCnt;
    repeat (40) @(negedge clk);
    chk(bitRiseCnt == rises, "R2 no bitClk while disabled", bitRiseCnt - rises, 0);

    // R2/R3/R5/R6/R8/R10: early MSB, fast divider, 20-slot frame
    pushFrame(1'b0, 1'b0);
    serClkEn = 1'b1;
    @(negedge clk);
    chk(frameSync && !bitClk && txShift, "R2 slot 0 one cycle after enable",
        int'({frameSync, bitClk, txShift}), 5);
    waitSync(2);
    chk(bitPeriod == 2, "R3 bit period div0", bitPeriod, 2);
    chk(framePeriod == 40, "R5 frame period 20 slots", framePeriod, 40);
    chk(syncWidth == 2, "R5 sync width one bit", syncWidth, 2);
    chk(txPerFrame == 16, "R6 tx strobes per frame", txPerFrame, 16);
    chk(rxPerFrame == 16, "R8 rx strobes per frame", rxPerFrame, 16);
    chk(!validBeforeSync, "R10 no data in last slot", int'(validBeforeSync), 0);
    chk(txQ.size() == 0 && rxQ.size() == 0, "R6 scoreboard drained",
        txQ.size() + rxQ.size(), 0);

    // R2: disabling returns to idle
    stopPort();
    rises = bitRiseCnt;
    repeat (30) @(negedge clk);
    chk(!bitClk && !frameSync && !txValid && bitRiseCnt == rises,
        "R2 idle after disable", bitRiseCnt - rises, 0);

    // R7/R3/R5: late MSB, divider 2, 25-slot frame
    txLate = 1'b1; rxLate = 1'b1; bitDivCfg = 9'd2; frameDivCfg = 9'd24;
    pushFrame(1'b1, 1'b1);
    serClkEn = 1'b1;
    waitSync(2);
    chk(bitPeriod == 6, "R3 bit period div2", bitPeriod, 6);
    chk(framePeriod == 150, "R5 frame period 25 slots", framePeriod, 150);
    chk(txQ.size() == 0 && rxQ.size() == 0, "R7 late scoreboard drained",
        txQ.size() + rxQ.size(), 0);
    stopPort();

    // R4: audio source, tick every third cycle
    srcSel = 1'b0; txLate = 1'b0; rxLate = 1'b0;
    bitDivCfg = 9'd1; frameDivCfg = 9'd19;
    serClkEn = 1'b1;
    waitSync(3);
    chk(bitPeriod == 12, "R4 audio source bit period", bitPeriod, 12);
    chk(framePeriod == 240, "R4 audio source frame period", framePeriod, 240);
    stopPort();

    // R9: mid-frame divider change
    srcSel = 1'b1; bitDivCfg = 9'd0; frameDivCfg = 9'd19;
    serClkEn = 1'b1;
    waitSync(1);
    repeat (5) @(negedge clk);
    bitDivCfg = 9'd1; frameDivCfg = 9'd24;
    waitSync(1);
    chk(framePeriod == 40, "R9 current frame unchanged", framePeriod, 40);
    waitSync(1);
    chk(framePeriod == 100, "R9 next frame uses new dividers", framePeriod, 100);
    chk(bitPeriod == 4, "R9 new bit period", bitPeriod, 4);
    stopPort();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule